// File: doc/BRIEF.md
# Oversampled Asynchronous Frame Receiver

This block turns an asynchronous serial line into received characters. A baud generator outside the block supplies a tick at sixteen times the bit rate. The receiver finds a start bit on that tick grid and samples each following bit once, at the centre of its bit period. The bits collect in a shift register. When the frame ends, the character is handed to a receive data register according to the error rules.

The character format is set by level inputs:
- seven or eight data bits, sent least significant bit first;
- an optional parity bit, even or odd;
- one or two stop bits;
- a multiprocessor format, in which an address/data marker bit takes the place of the parity bit.

The status flags are held outside the block. The receive-full and error-active states come in as inputs. The block reports one-cycle event pulses that tell the status logic what to set: receive-full, parity error, framing error, overrun, and the received marker value.

Top module: `async_rx_frame`

## Requirements
- R1: For a clean frame with `full_in` low, the data bits (first received bit in `rdata[0]`) are written to `rdata`. `rx_full_set` pulses for one cycle in the same cycle. At most one of `rx_full_set` and `ovr_set` is high in any cycle.
- R2: With `fmt_seven` high, exactly seven data bits are received and `rdata[7]` reads 0.
- R3: With `par_en` high and `mp_mode` low, one parity bit follows the data. `per_set` pulses when the number of 1s in data plus parity is odd while `par_odd` is 0, or even while `par_odd` is 1. The data is still written to `rdata`, but `rx_full_set` does not pulse.
- R4: When the first stop bit is sampled as 0, `fer_set` pulses. The data is still written to `rdata`, but `rx_full_set` does not pulse.
- R5: With `two_stop` high, the second stop bit is not checked. A 0 there raises no error and does not start a new frame.
- R6: If a frame ends while `full_in` is 1, `ovr_set` pulses. `rdata` keeps its earlier value and `rx_full_set` does not pulse.
- R7: With `mp_mode` high, the bit after the data is a marker bit and no parity bit is present. At frame end, `mpb_stb` pulses with `mpb_val` equal to the marker bit.
- R8: A start is accepted only if the line is still low at the start bit's centre sample, eight ticks after the falling edge is seen. Otherwise the receiver returns to idle and reports nothing.
- R9: While `rx_en` is low, the receiver stays idle, aborts any frame in progress and reports no events. `rdata` keeps its value.
- R10: While `err_in` is high, no new frame is started.
- R11: After reset, `rdata` is 0 and no event output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| rx_en | input | 1 | Receive enable |
| err_in | input | 1 | Any receive error flag is set |
| full_in | input | 1 | Receive-full flag is set |
| fmt_seven | input | 1 | 1: seven data bits, 0: eight |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even |
| two_stop | input | 1 | Two stop bits |
| mp_mode | input | 1 | Multiprocessor marker format |
| rdata | output | 8 | Receive data register |
| rx_full_set | output | 1 | Pulse: set receive-full |
| per_set | output | 1 | Pulse: parity error |
| fer_set | output | 1 | Pulse: framing error |
| ovr_set | output | 1 | Pulse: overrun |
| mpb_stb | output | 1 | Pulse: marker bit received |
| mpb_val | output | 1 | Received marker value |

## Verification
The assertions check the following on every cycle:
- Receive-full is never raised together with an error or an overrun.
- An overrun leaves the data register untouched.
- A seven-bit load clears the top bit.
- The receiver drops to idle when disabled and starts nothing while an error is active.
- Marker reports appear only in multiprocessor format.

Only the bench's frames can show that the right bits land in the right positions, and that the parity sense is correct for both settings. The same holds for these behaviours:
- the second stop bit is really ignored;
- a glitch shorter than half a bit is rejected;
- an aborted frame leaves no trace.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_EXTRA = 3'd3,
        ST_STOP  = 3'd4,
        ST_STOP2 = 3'd5
    } rx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;
    logic [STAGES-1:0] pipe_d;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic run,
    output logic mid
);
    localparam int CW  = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int MID = OVS / 2 - 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (run && tick) begin
            if (cnt_q == CW'(OVS - 1)) cnt_d = '0;
            else                       cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign mid = run && tick && !restart && (cnt_q == CW'(MID));
endmodule

// File: rtl/srx_parity.sv
module srx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              seven,
    input  logic              pbit,
    input  logic              odd,
    output logic              bad
);
    logic [DATA_W-1:0] mask;

    always_comb begin
        mask = '1;
        if (seven) mask[DATA_W-1] = 1'b0;
        bad = (^(data & mask)) ^ pbit ^ odd;
    end
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              tick16,
    input  logic              rx_en,
    input  logic              err_in,
    input  logic              full_in,
    input  logic              fmt_seven,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              mp_mode,
    output logic [DATA_W-1:0] rdata,
    output logic              rx_full_set,
    output logic              per_set,
    output logic              fer_set,
    output logic              ovr_set,
    output logic              mpb_stb,
    output logic              mpb_val
);
    localparam int IW = $clog2(DATA_W);

    typedef struct packed {
        rx_state_e         st;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] sr;
        logic              xbit;
        logic [DATA_W-1:0] rdata;
        logic              full_p;
        logic              per_p;
        logic              fer_p;
        logic              ovr_p;
        logic              mpb_p;
        logic              mpb_v;
    } regs_t;

    regs_t r_q, r_d;
    logic  line, mid, restart, run, par_bad;
    logic [IW-1:0] last_idx;

    srx_sync #(.STAGES(SYNC_N)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line)
    );

    srx_bit_timer #(.OVS(OVS)) i_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .restart(restart), .run(run), .mid(mid)
    );

    srx_parity #(.DATA_W(DATA_W)) i_par (
        .data(r_q.sr), .seven(fmt_seven), .pbit(r_q.xbit),
        .odd(par_odd), .bad(par_bad)
    );

    assign run      = (r_q.st != ST_IDLE);
    assign last_idx = fmt_seven ? IW'(DATA_W - 2) : IW'(DATA_W - 1);

    always_comb begin
        r_d        = r_q;
        r_d.full_p = 1'b0;
        r_d.per_p  = 1'b0;
        r_d.fer_p  = 1'b0;
        r_d.ovr_p  = 1'b0;
        r_d.mpb_p  = 1'b0;
        restart    = 1'b0;
        if (!rx_en) begin
            r_d.st = ST_IDLE;
        end else begin
            case (r_q.st)
                ST_IDLE: begin
                    if (!err_in && tick16 && !line) begin
                        r_d.st  = ST_START;
                        restart = 1'b1;
                    end
                end
                ST_START: begin
                    if (mid) begin
                        if (!line) begin
                            r_d.st  = ST_DATA;
                            r_d.idx = '0;
                            r_d.sr  = '0;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    if (mid) begin
                        r_d.sr[r_q.idx] = line;
                        if (r_q.idx == last_idx)
                            r_d.st = (par_en || mp_mode) ? ST_EXTRA : ST_STOP;
                        else
                            r_d.idx = r_q.idx + IW'(1);
                    end
                end
                ST_EXTRA: begin
                    if (mid) begin
                        r_d.xbit = line;
                        r_d.st   = ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (mid) begin
                        r_d.fer_p = !line;
                        r_d.per_p = par_en && !mp_mode && par_bad;
                        if (full_in) begin
                            r_d.ovr_p = 1'b1;
                        end else begin
                            r_d.rdata  = r_q.sr;
                            r_d.full_p = line && !(par_en && !mp_mode && par_bad);
                        end
                        if (mp_mode) begin
                            r_d.mpb_p = 1'b1;
                            r_d.mpb_v = r_q.xbit;
                        end
                        r_d.st = two_stop ? ST_STOP2 : ST_IDLE;
                    end
                end
                ST_STOP2: begin
                    if (mid) r_d.st = ST_IDLE;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata       = r_q.rdata;
    assign rx_full_set = r_q.full_p;
    assign per_set     = r_q.per_p;
    assign fer_set     = r_q.fer_p;
    assign ovr_set     = r_q.ovr_p;
    assign mpb_stb     = r_q.mpb_p;
    assign mpb_val     = r_q.mpb_v;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_full_set, ovr_set}));                                  // R1
    AST_SEVEN_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full_set && $past(fmt_seven)) |-> !rdata[DATA_W-1]);            // R2
    AST_ERR_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (per_set || fer_set) |-> !rx_full_set);                             // R3
    AST_FULL_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full_set |-> $past(!full_in));                                   // R6
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |-> $stable(rdata));                                        // R6
    AST_MPB_ONLY_MP: assert property (@(posedge clk) disable iff (!rst_n)
        mpb_stb |-> $past(mp_mode));                                        // R7
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (r_q.st == ST_IDLE));                                    // R9
    AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && err_in) |=> (r_q.st == ST_IDLE));             // R10
endmodule

// File: tb/test_async_rx_frame.sv
module test_async_rx_frame;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1, tick16 = 1'b1, rx_en = 1'b0, err_in = 1'b0, full_in = 1'b0;
    logic fmt_seven = 1'b0, par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0, mp_mode = 1'b0;
    logic [7:0] rdata;
    logic rx_full_set, per_set, fer_set, ovr_set, mpb_stb, mpb_val;

    always #10 clk = ~clk;

    async_rx_frame i_async_rx_frame (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .rx_en(rx_en),
        .err_in(err_in), .full_in(full_in), .fmt_seven(fmt_seven), .par_en(par_en),
        .par_odd(par_odd), .two_stop(two_stop), .mp_mode(mp_mode), .rdata(rdata),
        .rx_full_set(rx_full_set), .per_set(per_set), .fer_set(fer_set),
        .ovr_set(ovr_set), .mpb_stb(mpb_stb), .mpb_val(mpb_val)
    );

    // event capture
    logic cap_clr = 1'b1;
    logic [7:0] n_full, n_per, n_fer, n_ovr, n_mpb;
    logic mpb_last;
    always_ff @(posedge clk) begin
        if (cap_clr) begin
            n_full <= '0; n_per <= '0; n_fer <= '0; n_ovr <= '0; n_mpb <= '0;
            mpb_last <= 1'b0;
        end else begin
            n_full <= n_full + 8'(rx_full_set);
            n_per  <= n_per + 8'(per_set);
            n_fer  <= n_fer + 8'(fer_set);
            n_ovr  <= n_ovr + 8'(ovr_set);
            n_mpb  <= n_mpb + 8'(mpb_stb);
            if (mpb_stb) mpb_last <= mpb_val;
        end
    end

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_cap();
        @(negedge clk) cap_clr = 1'b1;
        @(negedge clk) cap_clr = 1'b0;
    endtask

    task automatic send_bit(input logic v);
        @(negedge clk) rxd = v;
        repeat (15) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic mpbit, input logic flip,
                              input logic s1, input logic s2);
        logic p;
        int nb;
        nb = fmt_seven ? 7 : 8;
        p = (fmt_seven ? ^d[6:0] : ^d) ^ par_odd ^ flip;
        send_bit(1'b0);
        for (int i = 0; i < nb; i++) send_bit(d[i]);
        if (mp_mode)     send_bit(mpbit);
        else if (par_en) send_bit(p);
        send_bit(s1);
        if (two_stop) send_bit(s2);
        @(negedge clk) rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0] data;
        logic seven, pen, podd, two, mp, mpbit, flip, s1, s2, full;
        logic e_full, e_per, e_fer, e_ovr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{8'hA5, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R1
        '{8'h3C, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R3 even ok
        '{8'h3D, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R3 odd ok
        '{8'hDA, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R2
        '{8'h81, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0}, // R3 bad
        '{8'h7E, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0}, // R4
        '{8'hC3, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R5
        '{8'h11, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b1}, // R6
        '{8'h96, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R7
        '{8'h69, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0}, // R7
        '{8'h2B, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0}, // R3 odd bad
        '{8'h55, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b1,1'b0}  // R4
    };

    logic [7:0] exp_rd;

    initial begin
        exp_rd = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 rdata", rdata, 0);
        chk("R11 events", {rx_full_set, per_set, fer_set, ovr_set, mpb_stb}, 0);
        rx_en = 1'b1;
        clear_cap();

        for (int v = 0; v < NV; v++) begin
            fmt_seven = VEC[v].seven; par_en = VEC[v].pen; par_odd = VEC[v].podd;
            two_stop = VEC[v].two; mp_mode = VEC[v].mp; full_in = VEC[v].full;
            clear_cap();
            send_frame(VEC[v].data, VEC[v].mpbit, VEC[v].flip, VEC[v].s1, VEC[v].s2);
            if (!VEC[v].full) exp_rd = VEC[v].seven ? (VEC[v].data & 8'h7F) : VEC[v].data;
            chk($sformatf("R1 full vec%0d", v), n_full, VEC[v].e_full);
            chk($sformatf("R3 per vec%0d", v), n_per, VEC[v].e_per);
            chk($sformatf("R4 fer vec%0d", v), n_fer, VEC[v].e_fer);
            chk($sformatf("R6 ovr vec%0d", v), n_ovr, VEC[v].e_ovr);
            chk($sformatf("R2 rdata vec%0d", v), rdata, exp_rd);
            if (VEC[v].mp) begin
                chk($sformatf("R7 mpb count vec%0d", v), n_mpb, 1);
                chk($sformatf("R7 mpb value vec%0d", v), mpb_last, VEC[v].mpbit);
            end else begin
                chk($sformatf("R7 no mpb vec%0d", v), n_mpb, 0);
            end
        end
        fmt_seven = 0; par_en = 0; par_odd = 0; two_stop = 0; mp_mode = 0; full_in = 0;

        // R8 short glitch rejected
        clear_cap();
        @(negedge clk) rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        chk("R8 glitch events", n_full + n_per + n_fer + n_ovr, 0);
        chk("R8 glitch rdata", rdata, exp_rd);
        send_frame(8'h4E, 1'b0, 1'b0, 1'b1, 1'b1);
        exp_rd = 8'h4E;
        chk("R8 frame after glitch", n_full, 1);
        chk("R8 rdata after glitch", rdata, exp_rd);

        // R9 abort mid-frame
        clear_cap();
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        @(negedge clk) rx_en = 1'b0;
        for (int i = 0; i < 7; i++) send_bit(i[0]);
        @(negedge clk) rxd = 1'b1;
        repeat (30) @(negedge clk);
        rx_en = 1'b1;
        repeat (30) @(negedge clk);
        chk("R9 abort events", n_full + n_per + n_fer + n_ovr, 0);
        chk("R9 abort rdata", rdata, exp_rd);
        // R9 whole frame while disabled
        @(negedge clk) rx_en = 1'b0;
        send_frame(8'hF0, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R9 disabled events", n_full + n_per + n_fer + n_ovr, 0);
        chk("R9 disabled rdata", rdata, exp_rd);
        rx_en = 1'b1;

        // R10 error active blocks start
        clear_cap();
        err_in = 1'b1;
        send_frame(8'h0F, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R10 blocked events", n_full + n_per + n_fer + n_ovr, 0);
        chk("R10 blocked rdata", rdata, exp_rd);
        err_in = 1'b0;
        send_frame(8'h0F, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R10 resumes", n_full, 1);
        chk("R10 resumed rdata", rdata, 8'h0F);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule